// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a 16-bit watchdog that counts down by one on every slow-clock tick enable. Software keeps it from expiring by issuing a restart: a control write that carries an 8-bit key in its top byte. A restart is honoured only when the count has already fallen to or below a programmed window value. A keyed restart that arrives while the count is still above the window is treated as a fault. When the count reaches zero the watchdog expires. It then raises a sticky underflow flag and the fault output, and it can request a system reset.

A single mode write sets the reload value, the window value, a disable bit and a reset-enable bit. Only the first mode write after reset takes effect. After that the settings are locked, the disable choice included. The two event flags clear on a status read strobe. Until the mode write arrives, the watchdog runs with an all-ones reload value, an all-ones window and the reset request disabled.

The control logic is a three-state machine. COUNT is the running state. EXPIRED is entered on underflow: the count rests at zero and the reset request is driven. STOPPED is entered when the mode write sets the disable bit, and it is never left until reset. The transitions are:
- commit: a mode write to COUNT or STOPPED;
- expire: COUNT to EXPIRED on a tick at a count of one or less;
- revive: EXPIRED to COUNT on a valid restart.

Top module: `keyed_window_wdt`

## Requirements
- R1: While in COUNT, each cycle with `tick` high and no accepted write lowers `count` by exactly one. A cycle with neither `tick` nor `wr_en` leaves `count` unchanged.
- R2: A restart command is a write with `wr_sel`=0, the key 0xA5 in `wr_data[41:34]` and `wr_data[0]`=1. A control write with any other key changes neither `count` nor any flag.
- R3: A mode write has `wr_sel`=1 and uses these fields: reload in `wr_data[15:0]`, window in `wr_data[31:16]`, disable in bit 32, reset-enable in bit 33. The first such write after reset loads `count` with the new reload value and sets `stat_locked`.
- R4: Once `stat_locked` is set, later mode writes change nothing, and `stat_locked` stays high until reset.
- R5: A restart while `count` is less than or equal to the window loads `count` with the reload value.
- R6: A restart while `count` is greater than the window leaves `count` unchanged and sets `stat_early` and `fault`.
- R7: In COUNT, a tick with `count` at 1 or 0 sets `count` to 0, sets `stat_underflow` and `fault`, and enters EXPIRED. No further ticks change `count` while in EXPIRED.
- R8: `reset_req` is high exactly while EXPIRED, and only if the reset-enable bit was set by the mode write.
- R9: A restart in EXPIRED reloads `count`, returns to COUNT and drops `reset_req`.
- R10: A `rd_stat` pulse clears both event flags one cycle later, and `fault` falls with them, unless a new event occurs in that same cycle.
- R11: With the disable bit set, `count` is frozen. Ticks and restarts are ignored and no flag is raised.
- R12: After reset, `count` is 0xFFFF, all flags and outputs are low, and a restart is accepted at any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow-clock tick enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control (restart) write, 1 = mode write |
| wr_data | input | 42 | Write data; key in [41:34] |
| rd_stat | input | 1 | Status read strobe; clears event flags |
| count | output | 16 | Current counter value |
| stat_underflow | output | 1 | Sticky underflow flag |
| stat_early | output | 1 | Sticky early-restart flag |
| stat_locked | output | 1 | Mode register has been written |
| fault | output | 1 | Either event flag is set |
| reset_req | output | 1 | Reset request while expired |

## Verification
The assertions check, on every cycle, these properties:
- the count holds when no tick or write arrives, and stays frozen in STOPPED;
- the lock never drops;
- an early keyed restart always raises the early flag without touching the count;
- an underflow flag only ever rises with the count at zero, and the reset request only ever appears in EXPIRED.

Only the bench's scenarios can show the cases that need expected values: the exact reload value after a restart, the window boundary over a sweep of windows and restart times, the ignored second mode write, the wrong-key case, and clear-on-read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int          KEY_W   = 8;
    localparam logic [7:0]  WDT_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_EXPIRED = 2'd1,
        ST_STOPPED = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic [CNT_W-1:0] reload_in,
    input  logic [CNT_W-1:0] window_in,
    input  logic             rsten_in,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] window_q,
    output logic             rsten_q,
    output logic             locked_q,
    output logic             commit
);
    // only the first mode write after reset is taken
    assign commit = wr_mode && !locked_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            window_q <= '1;
            rsten_q  <= 1'b0;
            locked_q <= 1'b0;
        end else if (commit) begin
            reload_q <= reload_in;
            window_q <= window_in;
            rsten_q  <= rsten_in;
            locked_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_low
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign at_low = (cnt <= ONE);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '1;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - ONE;
    end
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt #(
    parameter int CNT_W = 16,
    localparam int DW   = 2*CNT_W + wdt_pkg::KEY_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_stat,
    output logic [CNT_W-1:0] count,
    output logic             stat_underflow,
    output logic             stat_early,
    output logic             stat_locked,
    output logic             fault,
    output logic             reset_req
);
    import wdt_pkg::*;

    localparam int DIS_BIT = 2*CNT_W;
    localparam int RST_BIT = 2*CNT_W + 1;

    wdt_state_e       state, state_nx;
    logic [CNT_W-1:0] reload_q, window_q, load_val;
    logic             rsten_q, commit, at_low;
    logic             load, dec, set_uf, set_er;
    logic             restart_cmd, uf_q, er_q;

    assign restart_cmd = wr_en && !wr_sel && wr_data[0]
                      && (wr_data[DW-1 -: KEY_W] == WDT_KEY);

    wdt_mode_reg #(.CNT_W(CNT_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_en && wr_sel),
        .reload_in (wr_data[CNT_W-1:0]),
        .window_in (wr_data[2*CNT_W-1:CNT_W]),
        .rsten_in  (wr_data[RST_BIT]),
        .reload_q  (reload_q),
        .window_q  (window_q),
        .rsten_q   (rsten_q),
        .locked_q  (stat_locked),
        .commit    (commit)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .cnt      (count),
        .at_low   (at_low)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nx;
    end

    // next state and datapath controls
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        load_val = reload_q;
        dec      = 1'b0;
        set_uf   = 1'b0;
        set_er   = 1'b0;
        unique case (state)
            ST_COUNT, ST_EXPIRED: begin
                if (commit) begin
                    load     = 1'b1;
                    load_val = wr_data[CNT_W-1:0];
                    state_nx = wr_data[DIS_BIT] ? ST_STOPPED : ST_COUNT;
                end else if (restart_cmd) begin
                    if (count <= window_q) begin
                        load     = 1'b1;
                        state_nx = ST_COUNT;
                    end else begin
                        set_er = 1'b1;
                    end
                end else if (tick && state == ST_COUNT) begin
                    if (at_low) begin
                        load     = 1'b1;
                        load_val = '0;
                        set_uf   = 1'b1;
                        state_nx = ST_EXPIRED;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            ST_STOPPED: state_nx = ST_STOPPED;
            default:    state_nx = ST_COUNT;
        endcase
    end

    // sticky event flags, clear on read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q <= 1'b0;
            er_q <= 1'b0;
        end else begin
            uf_q <= set_uf | (uf_q & ~rd_stat);
            er_q <= set_er | (er_q & ~rd_stat);
        end
    end

    // outputs
    always_comb begin
        stat_underflow = uf_q;
        stat_early     = er_q;
        fault          = uf_q | er_q;
        reset_req      = (state == ST_EXPIRED) && rsten_q;
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                wr_en,
    input logic                wr_sel,
    input logic [7:0]          key_f,
    input logic                go,
    input wdt_pkg::wdt_state_e state,
    input logic [CNT_W-1:0]    window,
    input logic [CNT_W-1:0]    count,
    input logic                stat_underflow,
    input logic                stat_early,
    input logic                stat_locked,
    input logic                reset_req
);
    import wdt_pkg::*;

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(count));

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_locked |=> stat_locked);

    assert_early_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && go && key_f == WDT_KEY && state != ST_STOPPED
         && count > window) |=> (stat_early && $stable(count)));

    assert_uf_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_underflow) |-> (count == '0));

    assert_req_expired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (state == ST_EXPIRED && count == '0));

    assert_stop_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED) |=> ($stable(count) && state == ST_STOPPED));
endmodule

bind keyed_window_wdt wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .key_f          (wr_data[DW-1 -: 8]),
    .go             (wr_data[0]),
    .state          (state),
    .window         (window_q),
    .count          (count),
    .stat_underflow (stat_underflow),
    .stat_early     (stat_early),
    .stat_locked    (stat_locked),
    .reset_req      (reset_req)
);

// File: tb/keyed_window_wdt_test.sv
module keyed_window_wdt_test;
    localparam int CNT_W = 16;
    localparam int DW    = 2*CNT_W + 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_stat = 1'b0;
    logic [DW-1:0]    wr_data = '0;
    logic [CNT_W-1:0] count;
    logic             stat_underflow, stat_early, stat_locked, fault, reset_req;
    int               errors = 0, checks = 0;

    always #5 clk = ~clk;

    keyed_window_wdt #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_stat(rd_stat), .count(count),
        .stat_underflow(stat_underflow), .stat_early(stat_early),
        .stat_locked(stat_locked), .fault(fault), .reset_req(reset_req)
    );

    function automatic logic [DW-1:0] mode_w(int rl, int wn, bit dis, bit re);
        return {8'h00, re, dis, wn[15:0], rl[15:0]};
    endfunction

    function automatic logic [DW-1:0] ctrl_w(logic [7:0] key);
        return {key, 33'b0, 1'b1};
    endfunction

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic write(bit sel, logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(int n);
        if (n > 0) begin
            @(negedge clk); tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic read_stat();
        @(negedge clk); rd_stat = 1'b1;
        @(negedge clk); rd_stat = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset();
        check(count, 16'hFFFF, "R12 count");
        check({stat_underflow, stat_early, stat_locked, fault, reset_req}, 0, "R12 flags");
        // R1 idle hold, then decrement
        repeat (3) @(negedge clk);
        check(count, 16'hFFFF, "R1 idle");
        ticks(5);
        check(count, 16'hFFFF - 5, "R1 decrement");
        // R12 default window accepts restart anywhere
        write(1'b0, ctrl_w(8'hA5));
        check(count, 16'hFFFF, "R12 default restart");
        check(stat_early, 0, "R12 no early");

        // R5/R6/R7 near-exhaustive window x restart-time sweep, reload 12
        for (int w = 0; w <= 12; w++) begin
            for (int t = 0; t <= 14; t++) begin
                int c;
                do_reset();
                write(1'b1, mode_w(12, w, 1'b0, 1'b0));
                ticks(t);
                c = (t >= 12) ? 0 : 12 - t;
                check(count, c, "R1 swept count");
                check(stat_underflow, (t >= 12) ? 1 : 0, "R7 swept underflow");
                write(1'b0, ctrl_w(8'hA5));
                if (c <= w) begin
                    check(count, 12, "R5 reload in window");
                    check(stat_early, 0, "R5 no early");
                end else begin
                    check(count, c, "R6 count kept");
                    check(stat_early, 1, "R6 early flag");
                    check(fault, 1, "R6 fault");
                end
            end
        end

        // R2 wrong key ignored
        do_reset();
        write(1'b1, mode_w(10, 3, 1'b0, 1'b0));
        check(stat_locked, 1, "R3 locked");
        check(count, 10, "R3 reload applied");
        ticks(8);
        write(1'b0, ctrl_w(8'h5A));
        check(count, 2, "R2 wrong key count");
        check(fault, 0, "R2 wrong key no flag");
        ticks(1);
        write(1'b0, ctrl_w(8'hA4));
        check(count, 1, "R2 near key ignored");

        // R4 second mode write has no effect
        do_reset();
        write(1'b1, mode_w(12, 4, 1'b0, 1'b0));
        ticks(2);
        write(1'b1, mode_w(3, 15, 1'b1, 1'b1));
        check(count, 10, "R4 count untouched");
        ticks(1);
        check(count, 9, "R4 still counting");
        write(1'b0, ctrl_w(8'hA5));
        check(stat_early, 1, "R4 old window kept");
        check(stat_locked, 1, "R4 lock held");

        // R7/R8/R9/R10 underflow with and without reset enable
        for (int re = 0; re <= 1; re++) begin
            for (int rl = 1; rl <= 5; rl++) begin
                do_reset();
                write(1'b1, mode_w(rl, 0, 1'b0, re[0]));
                ticks(rl - 1);
                check(count, 1, "R7 before zero");
                check(fault, 0, "R7 no early fault");
                ticks(3);
                check(count, 0, "R7 rests at zero");
                check(stat_underflow, 1, "R7 underflow flag");
                check(reset_req, re, "R8 reset request");
                write(1'b0, ctrl_w(8'hA5));
                check(count, rl, "R9 reload after expiry");
                check(reset_req, 0, "R9 request dropped");
                read_stat();
                check(stat_underflow, 0, "R10 clear on read");
                check(fault, 0, "R10 fault cleared");
            end
        end

        // R10 early flag cleared by read
        do_reset();
        write(1'b1, mode_w(20, 2, 1'b0, 1'b0));
        write(1'b0, ctrl_w(8'hA5));
        check(stat_early, 1, "R10 early set");
        read_stat();
        check(stat_early, 0, "R10 early cleared");

        // R11 disabled watchdog
        do_reset();
        write(1'b1, mode_w(7, 0, 1'b1, 1'b1));
        check(count, 7, "R11 loaded");
        ticks(20);
        check(count, 7, "R11 frozen");
        write(1'b0, ctrl_w(8'hA5));
        check(count, 7, "R11 restart ignored");
        check({fault, reset_req}, 0, "R11 no fault");
        write(1'b1, mode_w(9, 9, 1'b0, 1'b0));
        ticks(2);
        check(count, 7, "R11 disable locked");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule